// File: doc/BRIEF.md
# Oversampling Serial Receiver with Register Port and Receive FIFO

This block receives asynchronous serial characters on one input line and hands them to a host through three byte-wide registers on an 8-bit I/O bus. The line is sampled sixteen times per bit period, and the sample rate comes from a base divider that matches a 1.8432 MHz reference. A start bit is accepted only if it is still low at its middle. Eight data bits then arrive least significant first, followed by an even parity bit and one stop bit. Each finished character goes into a small FIFO.

The host programs rate, enables and receiver power through a control register. It drains characters by reading the data register and polls a status register. That register holds sticky line-error bits, empty and full bits, and a saturating 2-bit occupancy code. Three separate interrupt lines report a full FIFO, available data and a latched error. Each line is gated by its own enable bit and by the receiver-on bit.

Top module: `serial_rx_port`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x08 (empty only) and all three interrupt lines are low.
- R2: A register access takes place only when `addr_en_n` is low and `addr` equals BASE_ADDR (data), BASE_ADDR+1 (control) or BASE_ADDR+2 (status). Any other address, or `addr_en_n` high, changes no state and does not pop the FIFO. The bus is driven only during a selected read.
- R3: Control register bits: [5] error interrupt enable, [4] receiver on, [3] data-ready interrupt enable, [2] full interrupt enable, [1:0] rate select. Bits [7:6] always read 0.
- R4: A start bit must still read low 8 sample ticks after the first low sample, or it is dropped. A low pulse shorter than half a bit yields no character. Data bits are taken LSB first at mid-bit.
- R5: Rate select 00, 01, 10 and 11 give bit periods of 16·BASE_DIV·12, ·6, ·3 and ·1 clock cycles.
- R6: The FIFO holds FIFO_DEPTH (4) characters and returns them in arrival order. A data register read pops one entry, and a data read while empty returns 0x00.
- R7: Status bits: [3] empty, [2] full, [1:0] occupancy saturating at 3. Bit 7 reads 0.
- R8: A character that completes while the FIFO is full is discarded and sets overrun, status bit 4.
- R9: A parity mismatch (even parity over data plus parity bit) sets bit 6. A low stop sample sets bit 5. The character is stored in both cases.
- R10: Bits 6..4 are sticky. A status read returns them and then clears them.
- R11: `irq_full` = full AND bit2 AND bit4. `irq_ready` = not-empty AND bit3 AND bit4. `irq_error` = any sticky error AND bit5 AND bit4. Each is registered.
- R12: While bit 4 is 0 the line is ignored and no character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_en_n | input | 1 | Active-low address valid qualifier |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | I/O address |
| bus_d | inout | 8 | Bidirectional data bus, released when not reading |
| rx_line | input | 1 | Serial input, idle high |
| irq_full | output | 1 | FIFO-full interrupt |
| irq_ready | output | 1 | Data-available interrupt |
| irq_error | output | 1 | Line-error interrupt |

## Verification
The bench builds the block with BASE_DIV = 2, FIFO_DEPTH = 4 and the default base address of 257. The short divider makes a bit at the fastest rate last 32 clocks, and the slowest rate 384 clocks. All four rate multipliers, a FIFO fill past overrun, parity and stop faults, and a sub-half-bit glitch therefore fit in one short run. Depth 4 is the smallest depth at which the saturating occupancy code and the full bit come apart from a plain count.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int CTL_ERR_IE = 5;
  localparam int CTL_ON     = 4;
  localparam int CTL_RDY_IE = 3;
  localparam int CTL_FUL_IE = 2;

  // Multiplier of the base 16x tick period for each rate select value.
  function automatic int baud_mult(input logic [1:0] sel);
    case (sel)
      2'b00:   return 12;
      2'b01:   return 6;
      2'b10:   return 3;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_baud.sv
module serial_rx_baud
  import serial_rx_pkg::*;
#(
  parameter int BASE_DIV = 27
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int MAX_DIV = BASE_DIV * 12;
  localparam int CW      = $clog2(MAX_DIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'(BASE_DIV * baud_mult(sel) - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rx,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              frm_bad,
  output logic              busy
);
  localparam int OCW = $clog2(OSR);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OCW-1:0] MID  = OCW'(OSR / 2 - 1);
  localparam logic [OCW-1:0] LAST = OCW'(OSR - 1);

  rx_state_e         state;
  logic [OCW-1:0]    ocnt;
  logic [BCW-1:0]    bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;

  assign busy = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= RX_IDLE;
      ocnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_bad <= 1'b0;
      frm_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx) begin
              state <= RX_START;
              ocnt  <= '0;
            end
          end
          RX_START: begin
            if (ocnt == MID) begin
              ocnt <= '0;
              bidx <= '0;
              state <= rx ? RX_IDLE : RX_DATA;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (ocnt == LAST) begin
              ocnt  <= '0;
              shreg <= {rx, shreg[DATA_W-1:1]};
              if (bidx == BCW'(DATA_W - 1)) state <= RX_PAR;
              else bidx <= bidx + 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (ocnt == LAST) begin
              ocnt    <= '0;
              par_bit <= rx;
              state   <= RX_STOP;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (ocnt == LAST) begin
              ocnt    <= '0;
              done    <= 1'b1;
              data    <= shreg;
              par_bad <= (^shreg) ^ par_bit;
              frm_bad <= !rx;
              state   <= RX_IDLE;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import serial_rx_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(257),
  parameter int              BASE_DIV    = 27,
  parameter int              FIFO_DEPTH  = 4,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_en_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        bus_d,
  input  logic              rx_line,
  output logic              irq_full,
  output logic              irq_ready,
  output logic              irq_error
);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  // Serial line synchronizer
  logic [SYNC_STAGES-1:0] rx_sync;
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) rx_sync[i] <= rst ? 1'b1 : rx_line;
    end else begin : g_next
      always_ff @(posedge clk) rx_sync[i] <= rst ? 1'b1 : rx_sync[i-1];
    end
  end
  logic rx_s;
  assign rx_s = rx_sync[SYNC_STAGES-1];

  // Bus strobe edge detection
  logic rd_s1, rd_s2, wr_s1, wr_s2;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1 <= 1'b1; rd_s2 <= 1'b1;
      wr_s1 <= 1'b1; wr_s2 <= 1'b1;
    end else begin
      rd_s1 <= rd_n; rd_s2 <= rd_s1;
      wr_s1 <= wr_n; wr_s2 <= wr_s1;
    end
  end

  logic hit_data, hit_ctl, hit_sts, hit_any, rd_stb, wr_stb;
  assign hit_data = !addr_en_n && (addr == BASE_ADDR);
  assign hit_ctl  = !addr_en_n && (addr == BASE_ADDR + ADDR_W'(1));
  assign hit_sts  = !addr_en_n && (addr == BASE_ADDR + ADDR_W'(2));
  assign hit_any  = hit_data || hit_ctl || hit_sts;
  assign rd_stb   = rd_s2 && !rd_s1;
  assign wr_stb   = wr_s2 && !wr_s1;

  logic [7:0] ctl_q;
  logic       rx_on;
  assign rx_on = ctl_q[CTL_ON];

  // Datapath
  logic            tick, rx_done, rx_par_bad, rx_frm_bad, rx_busy;
  logic [7:0]      rx_byte, fifo_rd;
  logic [CNTW-1:0] fifo_cnt;
  logic            fifo_empty, fifo_full, pop;

  serial_rx_baud #(.BASE_DIV(BASE_DIV)) u_baud (
    .clk(clk), .rst(rst), .en(rx_on), .sel(ctl_q[1:0]), .tick(tick)
  );

  serial_rx_frame #(.DATA_W(8), .OSR(16)) u_frame (
    .clk(clk), .rst(rst), .en(rx_on), .tick(tick), .rx(rx_s),
    .done(rx_done), .data(rx_byte), .par_bad(rx_par_bad),
    .frm_bad(rx_frm_bad), .busy(rx_busy)
  );

  assign pop = rd_stb && hit_data && !fifo_empty;

  serial_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_done), .wdata(rx_byte), .pop(pop),
    .rdata(fifo_rd), .count(fifo_cnt), .empty(fifo_empty), .full(fifo_full)
  );

  // Sticky errors: {parity, framing, overrun}
  logic [2:0] err_q, err_new;
  logic       err_clr;
  assign err_clr = rd_stb && hit_sts;
  assign err_new = rx_done ? {rx_par_bad, rx_frm_bad, fifo_full} : 3'b000;

  logic [1:0] occ;
  assign occ = (fifo_cnt > CNTW'(3)) ? 2'd3 : fifo_cnt[1:0];

  logic [7:0] sts;
  assign sts = {1'b0, err_q, fifo_empty, fifo_full, occ};

  logic [7:0] rdata_q;
  logic       oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= 8'h00;
      err_q     <= 3'b000;
      rdata_q   <= 8'h00;
      oe_q      <= 1'b0;
      irq_full  <= 1'b0;
      irq_ready <= 1'b0;
      irq_error <= 1'b0;
    end else begin
      if (wr_stb && hit_ctl) ctl_q <= bus_d & 8'h3F;
      err_q <= (err_q & ~{3{err_clr}}) | err_new;
      if (rd_stb) begin
        if (hit_data)     rdata_q <= fifo_empty ? 8'h00 : fifo_rd;
        else if (hit_ctl) rdata_q <= ctl_q;
        else if (hit_sts) rdata_q <= sts;
      end
      oe_q      <= !rd_s1 && hit_any;
      irq_full  <= fifo_full   && ctl_q[CTL_FUL_IE] && rx_on;
      irq_ready <= !fifo_empty && ctl_q[CTL_RDY_IE] && rx_on;
      irq_error <= (|err_q)    && ctl_q[CTL_ERR_IE] && rx_on;
    end
  end

  assign bus_d = oe_q ? rdata_q : 8'bz;

endmodule

// File: rtl/serial_rx_port_chk.sv
module serial_rx_port_chk #(
  parameter int DEPTH = 4,
  parameter int CNTW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      ctl,
  input logic            oe,
  input logic            rd_sync,
  input logic [CNTW-1:0] cnt,
  input logic            empty,
  input logic            full,
  input logic            rx_done,
  input logic [2:0]      err,
  input logic            rx_busy,
  input logic            irq_full,
  input logic            irq_ready,
  input logic            irq_error
);
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH));

  a_r7_empty_full_excl: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  a_r8_overrun_latched: assert property (@(posedge clk) disable iff (rst)
    (rx_done && full) |=> err[0]);

  a_r11_ready_gated: assert property (@(posedge clk) disable iff (rst)
    irq_ready |-> $past(ctl[4] && ctl[3] && !empty));

  a_r11_full_gated: assert property (@(posedge clk) disable iff (rst)
    irq_full |-> $past(ctl[4] && ctl[2] && full));

  a_r11_error_gated: assert property (@(posedge clk) disable iff (rst)
    irq_error |-> $past(ctl[4] && ctl[5]));

  a_r12_off_idle: assert property (@(posedge clk) disable iff (rst)
    !ctl[4] |=> !rx_busy);

  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    oe |-> $past(!rd_sync));

  a_r3_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ctl[7:6] == 2'b00);
endmodule

bind serial_rx_port serial_rx_port_chk #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst(rst), .ctl(ctl_q), .oe(oe_q), .rd_sync(rd_s1),
  .cnt(fifo_cnt), .empty(fifo_empty), .full(fifo_full), .rx_done(rx_done),
  .err(err_q), .rx_busy(rx_busy), .irq_full(irq_full),
  .irq_ready(irq_ready), .irq_error(irq_error)
);

// File: tb/serial_rx_port_tb.sv
`timescale 1ns/1ps
module serial_rx_port_tb;
  localparam int BDIV = 2;
  localparam int BASE = 257;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_en_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [23:0] addr = '0;
  logic        drv = 1'b0;
  logic [7:0]  tb_d = '0;
  wire  [7:0]  bus_d;
  logic        rx_line = 1'b1;
  logic        irq_full, irq_ready, irq_error;

  assign bus_d = drv ? tb_d : 8'bz;

  always #10 clk = ~clk;

  serial_rx_port #(.ADDR_W(24), .BASE_ADDR(24'(BASE)), .BASE_DIV(BDIV),
                   .FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .addr_en_n(addr_en_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bus_d(bus_d), .rx_line(rx_line), .irq_full(irq_full),
    .irq_ready(irq_ready), .irq_error(irq_error)
  );

  int tests = 0, fails = 0;

  // Behavioural model
  byte unsigned q[$];
  logic [7:0] m_ctl = 8'h00;
  bit m_par = 0, m_frm = 0, m_ovr = 0;
  bit live = 0;

  function automatic logic [7:0] m_sts();
    int n = q.size();
    return {1'b0, m_par, m_frm, m_ovr, n == 0, n == 4, 2'(n > 3 ? 3 : n)};
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // R11: per-clock interrupt comparison against the model
  always @(posedge clk) begin
    #5;
    if (live) begin
      check("R11 irq", {5'd0, irq_full, irq_ready, irq_error},
            {5'd0, q.size() == 4 && m_ctl[2] && m_ctl[4],
                   q.size() > 0 && m_ctl[3] && m_ctl[4],
                   (m_par | m_frm | m_ovr) && m_ctl[5] && m_ctl[4]});
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
    live = 1;
  endtask

  task automatic bus_write(int a, logic [7:0] d, bit sel = 1);
    live = 0;
    @(negedge clk);
    addr_en_n = !sel; addr = 24'(a); tb_d = d; drv = 1;
    @(negedge clk); wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    @(negedge clk); drv = 0; addr_en_n = 1;
    if (sel && a == BASE + 1) m_ctl = d & 8'h3F;
    settle();
  endtask

  task automatic bus_read(int a, output logic [7:0] d, input bit sel = 1);
    live = 0;
    @(negedge clk);
    addr_en_n = !sel; addr = 24'(a);
    @(negedge clk); rd_n = 0;
    repeat (4) @(negedge clk);
    d = bus_d; rd_n = 1;
    @(negedge clk); addr_en_n = 1;
    if (sel && a == BASE && q.size() > 0) void'(q.pop_front());
    if (sel && a == BASE + 2) begin m_par = 0; m_frm = 0; m_ovr = 0; end
    settle();
  endtask

  // Sends one frame; mult = rate multiplier. bad_stop holds stop low for 3/4 bit.
  task automatic send(byte unsigned b, int mult, bit par_flip = 0, bit bad_stop = 0);
    int p = 16 * BDIV * mult;
    logic par = (^b) ^ par_flip;
    live = 0;
    @(negedge clk);
    rx_line = 0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_line = b[i]; repeat (p) @(negedge clk); end
    rx_line = par; repeat (p) @(negedge clk);
    if (bad_stop) begin rx_line = 0; repeat (p * 3 / 4) @(negedge clk); end
    rx_line = 1; repeat (p) @(negedge clk);
    if (m_ctl[4]) begin
      if (q.size() == 4) m_ovr = 1; else q.push_back(b);
      if (par_flip) m_par = 1;
      if (bad_stop) m_frm = 1;
    end
    settle();
  endtask

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 0;
    settle();
    // R1
    bus_read(BASE + 2, r); check("R1 status", r, 8'h08);
    bus_read(BASE + 1, r); check("R1 control", r, 8'h00);
    check("R1 irqs", {5'd0, irq_full, irq_ready, irq_error}, 8'h00);
    // R3
    bus_write(BASE + 1, 8'hFF);
    bus_read(BASE + 1, r); check("R3 unused bits zero", r, 8'h3F);
    // R2: deselected and foreign-address writes ignored
    bus_write(BASE + 1, 8'h00, 0);
    bus_write(BASE + 3, 8'h00);
    bus_read(BASE + 1, r); check("R2 write ignored", r, 8'h3F);
    // R4 / R7 / R6
    send(8'hA5, 1);
    bus_read(BASE + 2, r); check("R7 one entry", r, 8'h01);
    bus_read(BASE, r, 0);
    bus_read(BASE + 3, r);
    bus_read(BASE + 2, r); check("R2 no pop when deselected", r, 8'h01);
    bus_read(BASE, r); check("R4 byte A5", r, 8'hA5);
    bus_read(BASE, r); check("R6 empty read", r, 8'h00);
    bus_read(BASE + 2, r); check("R7 empty again", r, 8'h08);
    // R8 / R10 / R6 order
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1); send(8'h44, 1);
    bus_read(BASE + 2, r); check("R7 full level3", r, 8'h07);
    send(8'h55, 1);
    bus_read(BASE + 2, r); check("R8 overrun", r, 8'h17);
    bus_read(BASE + 2, r); check("R10 cleared", r, 8'h07);
    bus_read(BASE, r); check("R6 order 1", r, 8'h11);
    bus_read(BASE, r); check("R6 order 2", r, 8'h22);
    bus_read(BASE + 2, r); check("R7 level2", r, 8'h02);
    bus_read(BASE, r); check("R6 order 3", r, 8'h33);
    bus_read(BASE, r); check("R6 order 4", r, 8'h44);
    // R9 parity
    send(8'h3C, 1, 1);
    bus_read(BASE + 2, r); check("R9 parity", r, 8'h41);
    bus_read(BASE + 2, r); check("R10 parity cleared", r, 8'h01);
    bus_read(BASE, r); check("R9 parity byte kept", r, 8'h3C);
    // R9 framing
    send(8'h5A, 1, 0, 1);
    bus_read(BASE + 2, r); check("R9 framing", r, 8'h21);
    bus_read(BASE, r); check("R9 framing byte kept", r, 8'h5A);
    // R4 glitch rejection: 4 ticks low
    live = 0;
    @(negedge clk); rx_line = 0; repeat (4 * BDIV) @(negedge clk); rx_line = 1;
    repeat (400) @(negedge clk);
    settle();
    bus_read(BASE + 2, r); check("R4 glitch rejected", r, 8'h08);
    // R5 rate selects
    bus_write(BASE + 1, 8'h3D);
    send(8'h96, 6);
    bus_read(BASE, r); check("R5 rate 01", r, 8'h96);
    bus_write(BASE + 1, 8'h3E);
    send(8'h69, 3);
    bus_read(BASE, r); check("R5 rate 10", r, 8'h69);
    bus_write(BASE + 1, 8'h3C);
    send(8'h0F, 12);
    bus_read(BASE, r); check("R5 rate 00", r, 8'h0F);
    // R12 receiver off
    bus_write(BASE + 1, 8'h2F);
    send(8'hC3, 1);
    bus_write(BASE + 1, 8'h3F);
    bus_read(BASE + 2, r); check("R12 ignored when off", r, 8'h08);
    // R11 gating
    send(8'h77, 1);
    check("R11 ready on", {7'd0, irq_ready}, 8'h01);
    bus_write(BASE + 1, 8'h37);
    check("R11 ready disabled", {7'd0, irq_ready}, 8'h00);
    bus_write(BASE + 1, 8'h2F);
    check("R11 off gates", {7'd0, irq_ready}, 8'h00);
    bus_write(BASE + 1, 8'h3F);
    bus_read(BASE, r); check("R6 last byte", r, 8'h77);
    live = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule